// File: doc/BRIEF.md
# Corrector Status Serial Frame Transmitter

This block sends the result of an error-correction pass as a short serial frame on one output line. A client places a mode code, two failure flags and a count of corrected errors on the load inputs and raises a one-cycle load request. The block captures these values and emits an 11-cell frame. Each cell lasts a fixed number of system clocks, seven by default.

A frame is only sent when new status arrives, so frames have no fixed repetition rate. Every frame begins with a high start cell and ends with a low pause cell. The line rests low between frames.

If a request arrives while a frame is on the line, it is kept in a single holding slot. Its frame starts directly after the current pause cell. The `busy` output reports that a frame is on the line.

Top module: `cstat_serializer`

## Requirements
- R1: After reset and whenever no frame is in flight, `ser_out` is 0 and `busy` is 0.
- R2: A request accepted while idle starts the frame on the clock edge that samples it. The frame is 11 cells of CELL_CLKS (7) clocks each. `busy` is 1 for exactly those 77 clocks.
- R3: Cell 0 is the start cell, driven 1. Cell 10 is the pause cell, driven 0. Cells are sent in ascending order.
- R4: Cells 1 to 3 carry the 3-bit mode code, most significant bit first: cell 1 = mode[2], cell 3 = mode[0]. Defined codes: 000 first-level correction, 011 second-level correction, 100 corrector inactive.
- R5: Cell 4 carries the correction-impossible flag. Cell 5 carries the correction-too-risky flag.
- R6: Cells 6 to 9 carry the 4-bit corrected-error count, most significant bit first: cell 6 = count[3].
- R7: Field inputs are captured on the load cycle. Changing them later does not alter the frame in flight.
- R8: A request with an unused mode code (001, 010, 101, 110, 111) is sent unchanged, with no checking.
- R9: A request that arrives during a frame while the holding slot is empty is kept. Its start cell follows the current pause cell with no idle clock between them.
- R10: A request that arrives during a frame while the holding slot is full is dropped, and no frame is ever sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_req | input | 1 | One-cycle request to send a status frame |
| load_mode | input | 3 | Correction-mode code |
| load_impossible | input | 1 | Correction-impossible flag |
| load_risky | input | 1 | Correction-too-risky flag |
| load_count | input | 4 | Number of errors corrected |
| busy | output | 1 | A frame is on the line |
| ser_out | output | 1 | Serial status line |

## Verification
A request sampled at clock edge E makes `ser_out` show cell k during the clocks that follow edges E+7k through E+7k+6. `busy` rises at E and falls at E+77 unless a held request follows.

The bench drives a request just before an edge and removes it just after that edge. It then samples `ser_out` and `busy` on 77 consecutive falling edges and compares each sample with cell floor(i/7) of the frame it builds itself.

For held requests, the check for the second frame starts at the very next falling edge, which confirms that no idle clock separates the two frames. After a frame ends, the bench watches for idle clocks to show that a dropped request produced no frame.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
    localparam int MODE_W     = 3;
    localparam int CNT_W      = 4;
    localparam int FRAME_BITS = 1 + MODE_W + 2 + CNT_W + 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_FIRST_LVL  = 3'b000,
        MODE_SECOND_LVL = 3'b011,
        MODE_INACTIVE   = 3'b100
    } mode_e;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        frame_t           frame;
        logic             held_v;
        frame_t           held;
    } tx_state_t;
endpackage

// File: rtl/cstat_cell_timer.sv
module cstat_cell_timer #(
    parameter int CELL_CLKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cell_last
);
    localparam int CW = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELL_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign cell_last = run && (cnt_q == LAST);

    always_comb begin
        if (!run || cell_last) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/cstat_frame_pack.sv
module cstat_frame_pack
    import cstat_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              impossible,
    input  logic              risky,
    input  logic [CNT_W-1:0]  count,
    output frame_t            frame
);
    localparam int MODE_AT = 1;
    localparam int IMP_AT  = MODE_AT + MODE_W;
    localparam int RSK_AT  = IMP_AT + 1;
    localparam int CNT_AT  = RSK_AT + 1;

    assign frame[0]            = 1'b1;
    assign frame[IMP_AT]       = impossible;
    assign frame[RSK_AT]       = risky;
    assign frame[FRAME_BITS-1] = 1'b0;

    for (genvar i = 0; i < MODE_W; i++) begin : g_mode
        assign frame[MODE_AT + i] = mode[MODE_W-1-i];
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_cnt
        assign frame[CNT_AT + i] = count[CNT_W-1-i];
    end
endmodule

// File: rtl/cstat_serializer.sv
module cstat_serializer
    import cstat_pkg::*;
#(
    parameter int CELL_CLKS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_req,
    input  logic [2:0] load_mode,
    input  logic       load_impossible,
    input  logic       load_risky,
    input  logic [3:0] load_count,
    output logic       busy,
    output logic       ser_out
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    tx_state_t st_d, st_q;
    frame_t    in_frame;
    logic      cell_last;
    logic      frame_end;

    cstat_frame_pack u_pack (
        .mode       (load_mode),
        .impossible (load_impossible),
        .risky      (load_risky),
        .count      (load_count),
        .frame      (in_frame)
    );

    cstat_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.busy),
        .cell_last (cell_last)
    );

    assign frame_end = st_q.busy && cell_last && (st_q.idx == LAST_IDX);
    assign busy      = st_q.busy;
    assign ser_out   = st_q.busy && st_q.frame[st_q.idx];

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load_req) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.frame = in_frame;
            end
        end else if (frame_end) begin
            st_d.idx = '0;
            if (st_q.held_v) begin
                st_d.frame  = st_q.held;
                st_d.held_v = load_req;
                if (load_req) st_d.held = in_frame;
            end else if (load_req) begin
                st_d.frame = in_frame;
            end else begin
                st_d.busy = 1'b0;
            end
        end else begin
            if (cell_last) st_d.idx = st_q.idx + 1'b1;
            if (load_req && !st_q.held_v) begin
                st_d.held_v = 1'b1;
                st_d.held   = in_frame;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);
    assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ser_out);
    assert_pause_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.idx == LAST_IDX) |-> !ser_out);
    assert_cell_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && st_q.idx != $past(st_q.idx)) |-> $past(cell_last));
    assert_held_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held_v && !frame_end) |=> st_q.held_v);
    assert_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.held_v |-> busy);
endmodule

// File: tb/tb_cstat_serializer.sv
module tb_cstat_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_req = 1'b0;
    logic [2:0] load_mode = '0;
    logic       load_impossible = 1'b0;
    logic       load_risky = 1'b0;
    logic [3:0] load_count = '0;
    logic       busy, ser_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cstat_serializer dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_mode(load_mode),
        .load_impossible(load_impossible), .load_risky(load_risky),
        .load_count(load_count), .busy(busy), .ser_out(ser_out)
    );

    function automatic logic [10:0] mk(input logic [2:0] m, input logic i,
                                      input logic r, input logic [3:0] c);
        return {1'b0, c[0], c[1], c[2], c[3], r, i, m[0], m[1], m[2], 1'b1};
    endfunction

    task automatic drive(input logic [2:0] m, input logic i, input logic r,
                         input logic [3:0] c);
        load_req = 1'b1; load_mode = m; load_impossible = i;
        load_risky = r; load_count = c;
        @(posedge clk); #1;
        load_req = 1'b0;
        load_mode = ~m; load_impossible = ~i; load_risky = ~r; load_count = ~c;
    endtask

    task automatic check_frame(input logic [10:0] exp, input string tag);
        int bad = 0;
        logic a_s = 0, a_b = 0, e_s = 0;
        int where = 0;
        for (int k = 0; k < 77; k++) begin
            @(negedge clk);
            if (ser_out !== exp[k/7] || busy !== 1'b1) begin
                if (bad == 0) begin
                    a_s = ser_out; a_b = busy; e_s = exp[k/7]; where = k;
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s clk %0d cell %0d: ser_out=%b busy=%b expected ser_out=%b busy=1",
                     tag, where, where/7, a_s, a_b, e_s);
        end
    endtask

    task automatic check_idle(input int n, input string tag);
        int bad = 0;
        logic a_s = 0, a_b = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ser_out !== 1'b0 || busy !== 1'b0) begin
                bad++; a_s = ser_out; a_b = busy;
            end
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s idle: ser_out=%b busy=%b expected ser_out=0 busy=0",
                     tag, a_s, a_b);
        end
    endtask

    task automatic t_reset;
        check_idle(5, "R1 reset");
    endtask

    task automatic t_single(input logic [2:0] m, input logic i, input logic r,
                            input logic [3:0] c, input string tag);
        @(negedge clk);
        drive(m, i, r, c);
        check_frame(mk(m, i, r, c), tag);
        check_idle(3, {tag, " R1 after"});
    endtask

    task automatic t_held;
        @(negedge clk);
        drive(3'b000, 1'b1, 1'b1, 4'h5);
        fork
            begin
                check_frame(mk(3'b000, 1'b1, 1'b1, 4'h5), "R9 first");
                check_frame(mk(3'b011, 1'b0, 1'b1, 4'ha), "R9 held follows pause");
            end
            begin
                repeat (30) @(negedge clk);
                drive(3'b011, 1'b0, 1'b1, 4'ha);
            end
        join
        check_idle(4, "R9 after");
    endtask

    task automatic t_drop;
        @(negedge clk);
        drive(3'b100, 1'b0, 1'b0, 4'h1);
        fork
            begin
                check_frame(mk(3'b100, 1'b0, 1'b0, 4'h1), "R10 first");
                check_frame(mk(3'b000, 1'b1, 1'b0, 4'h6), "R10 held");
            end
            begin
                repeat (20) @(negedge clk);
                drive(3'b000, 1'b1, 1'b0, 4'h6);
                repeat (15) @(negedge clk);
                drive(3'b111, 1'b1, 1'b1, 4'hf);
            end
        join
        check_idle(90, "R10 dropped request sends nothing");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(3'b000, 1'b0, 1'b0, 4'h2, "R2 R3 R4 R5 R6 R7 first-level");
        t_single(3'b011, 1'b1, 1'b0, 4'hf, "R4 R6 second-level");
        t_single(3'b100, 1'b0, 1'b1, 4'h0, "R4 R5 inactive");
        t_single(3'b101, 1'b1, 1'b1, 4'h9, "R8 unused 101");
        t_single(3'b010, 1'b0, 1'b0, 4'h8, "R8 unused 010");
        t_held();
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule